// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit adds or subtracts two 64-bit operands that are viewed as a set of independent lanes. A lane-size select picks eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. A mode select picks how a lane handles a result that falls outside its range. In wrap-around mode the carry or borrow out of the lane is dropped. In signed saturation mode the result is clamped to the lane's signed limits. In unsigned saturation mode the result is clamped to the lane's unsigned limits. No carry ever passes from one lane into the next, and no overflow or carry indication leaves the block.

The result is registered. A request with the valid strobe high produces its result, together with an output valid pulse, one clock later. Saturation is defined only for 8-bit and 16-bit lanes. Saturation on 32-bit lanes, and any reserved code, is refused: the unit raises a dedicated illegal-operation pulse instead of a valid pulse and keeps the previous result.

Top module: `psimd_addsub`

## Requirements
- R1: With `arith_mode`=0 (wrap), `lane_sel`=0/1/2 (8/16/32-bit lanes) and `op_sub`=0, every lane of `result` equals the sum of the matching lanes of `opa` and `opb` modulo 2^n, and no carry passes between lanes.
- R2: In wrap mode the carry out of a lane is discarded: an 8-bit lane holding 0xFF plus 0x01 gives 0x00, and the lane above it is unaffected.
- R3: With `arith_mode`=1 (signed saturation) on 8-bit or 16-bit lanes, a lane result above 2^(n-1)-1 becomes 2^(n-1)-1, and a lane result below -2^(n-1) becomes -2^(n-1).
- R4: With `arith_mode`=2 (unsigned saturation) on 8-bit or 16-bit lanes, a lane result above 2^n-1 becomes 2^n-1, and a result below 0 becomes 0.
- R5: With `op_sub`=1 the unit computes `opa` minus `opb` per lane, with the same three modes and the same lane sizes as addition.
- R6: A request with `lane_sel`=3, or `arith_mode`=3, or a saturating mode on 32-bit lanes is illegal. One cycle later `illegal_op` is 1 and `out_valid` is 0, and `result` keeps its previous value.
- R7: A legal request with `in_valid`=1 sets `out_valid` to 1 and updates `result` on the next rising clock edge, so exactly one cycle of latency.
- R8: In a cycle after one with `in_valid`=0, `out_valid` and `illegal_op` are 0 and `result` is unchanged.
- R9: While `rst_n` is low, `out_valid` is 0, `illegal_op` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 0 add, 1 subtract (opa - opb) |
| lane_sel | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit lanes, 3: reserved |
| arith_mode | input | 2 | 0: wrap, 1: signed saturation, 2: unsigned saturation, 3: reserved |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after a legal request |
| result | output | 64 | Registered packed result |
| illegal_op | output | 1 | Pulses one cycle after an illegal request |

## Verification
Some properties are checked on every cycle: the one-cycle valid latency, the refusal of reserved codes and of 32-bit saturation, the hold of the result across idle and refused cycles, and the exclusivity of the valid and illegal pulses. Also checked on every cycle are lane-0 wrap addition and the unsigned-subtract floor on byte lanes. The full arithmetic of every lane, in every mode and lane size, can only be shown by the bench's scenarios. These include the clamps at the signed and unsigned limits, the isolation of carries at lane boundaries and subtraction across all modes, and the bench compares them with its own lane model.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  // Lane size codes
  typedef enum logic [1:0] {
    LANE_8   = 2'd0,
    LANE_16  = 2'd1,
    LANE_32  = 2'd2,
    LANE_RSV = 2'd3
  } lane_e;

  // Overflow policy codes
  typedef enum logic [1:0] {
    ARITH_WRAP = 2'd0,
    ARITH_SSAT = 2'd1,
    ARITH_USAT = 2'd2,
    ARITH_RSV  = 2'd3
  } arith_e;
endpackage

// File: rtl/psimd_decode.sv
module psimd_decode #(
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  parameter int MAX_SAT_W = 16
) (
  input  logic [1:0]           lane_sel,
  input  logic [1:0]           arith_mode,
  output logic                 legal,
  output logic [NUM_SIZES-1:0] size_oh,
  output logic                 sat_s,
  output logic                 sat_u
);
  import psimd_pkg::*;

  logic size_ok;
  logic mode_ok;
  logic sat_req;
  logic sat_ok;

  always_comb begin
    size_oh = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      if (int'(lane_sel) == k) size_oh[k] = 1'b1;
    end
  end

  assign size_ok = |size_oh;
  assign mode_ok = (arith_e'(arith_mode) != ARITH_RSV);
  assign sat_req = (arith_e'(arith_mode) == ARITH_SSAT) ||
                   (arith_e'(arith_mode) == ARITH_USAT);
  assign sat_ok  = ((BASE_W << lane_sel) <= MAX_SAT_W);
  assign legal   = size_ok && mode_ok && (!sat_req || sat_ok);
  assign sat_s   = (arith_e'(arith_mode) == ARITH_SSAT);
  assign sat_u   = (arith_e'(arith_mode) == ARITH_USAT);
endmodule

// File: rtl/psimd_lane.sv
module psimd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sat_s,
  input  logic         sat_u,
  output logic [W-1:0] y
);
  logic [W:0]   ext;
  logic [W-1:0] wrap;
  logic         u_ovf;
  logic         s_ovf;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b};
    else     ext = {1'b0, a} + {1'b0, b};
  end

  assign wrap  = ext[W-1:0];
  // Carry for add, borrow for subtract
  assign u_ovf = ext[W];
  assign s_ovf = (sub ? (a[W-1] != b[W-1]) : (a[W-1] == b[W-1])) &&
                 (wrap[W-1] != a[W-1]);

  always_comb begin
    if (sat_u && u_ovf) begin
      y = sub ? '0 : '1;
    end else if (sat_s && s_ovf) begin
      y = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end else begin
      y = wrap;
    end
  end
endmodule

// File: rtl/psimd_bank.sv
module psimd_bank #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub,
  input  logic              sat_s,
  input  logic              sat_u,
  output logic [DATA_W-1:0] y
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    psimd_lane #(.W(LANE_W)) u_lane (
      .a     (opa[i*LANE_W +: LANE_W]),
      .b     (opb[i*LANE_W +: LANE_W]),
      .sub   (sub),
      .sat_s (sat_s),
      .sat_u (sat_u),
      .y     (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/psimd_addsub.sv
module psimd_addsub #(
  parameter int DATA_W    = 64,
  parameter int BASE_W    = 8,
  parameter int NUM_SIZES = 3,
  parameter int MAX_SAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sub,
  input  logic [1:0]        lane_sel,
  input  logic [1:0]        arith_mode,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);
  logic                 legal;
  logic [NUM_SIZES-1:0] size_oh;
  logic                 sat_s;
  logic                 sat_u;
  logic [DATA_W-1:0]    bank_y [NUM_SIZES];
  logic [DATA_W-1:0]    sel_y;

  logic [DATA_W-1:0]    res_d, res_q;
  logic                 res_en;
  logic                 vld_d, vld_q;
  logic                 ill_d, ill_q;

  psimd_decode #(
    .BASE_W    (BASE_W),
    .NUM_SIZES (NUM_SIZES),
    .MAX_SAT_W (MAX_SAT_W)
  ) u_dec (
    .lane_sel   (lane_sel),
    .arith_mode (arith_mode),
    .legal      (legal),
    .size_oh    (size_oh),
    .sat_s      (sat_s),
    .sat_u      (sat_u)
  );

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
    psimd_bank #(
      .DATA_W (DATA_W),
      .LANE_W (BASE_W << k)
    ) u_bank (
      .opa   (opa),
      .opb   (opb),
      .sub   (op_sub),
      .sat_s (sat_s),
      .sat_u (sat_u),
      .y     (bank_y[k])
    );
  end

  // One-hot AND-OR selection of the lane-size variant
  always_comb begin
    sel_y = '0;
    for (int k = 0; k < NUM_SIZES; k++) begin
      sel_y = sel_y | (bank_y[k] & {DATA_W{size_oh[k]}});
    end
  end

  // Next state
  always_comb begin
    res_en = in_valid && legal;
    res_d  = sel_y;
    vld_d  = in_valid && legal;
    ill_d  = in_valid && !legal;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ill_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ill_q <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign illegal_op = ill_q;
  assign result     = res_q;
endmodule

// File: rtl/psimd_addsub_chk.sv
module psimd_addsub_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sub,
  input logic [1:0]        lane_sel,
  input logic [1:0]        arith_mode,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              illegal_op
);
  logic bad_req;
  assign bad_req = (lane_sel == 2'd3) || (arith_mode == 2'd3) ||
                   ((lane_sel == 2'd2) && (arith_mode != 2'd0));

  AST_LEGAL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bad_req) |=> (out_valid && !illegal_op)); // R7

  AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad_req) |=> (illegal_op && !out_valid)); // R6

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && bad_req) |=> $stable(result)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !illegal_op && $stable(result))); // R8

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && illegal_op)); // R6

  AST_WRAP_BYTE0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && arith_mode == 2'd0 && !op_sub) |=>
    (result[7:0] == 8'($past(opa[7:0]) + $past(opb[7:0])))); // R2

  AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'd0 && arith_mode == 2'd2 && op_sub &&
     (opa[7:0] < opb[7:0])) |=> (result[7:0] == 8'h00)); // R4

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STATE: assert (!out_valid && !illegal_op); // R9
    end
  end
endmodule

bind psimd_addsub psimd_addsub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_psimd_addsub.sv
`timescale 1ns/1ps
module tb_psimd_addsub;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        op_sub;
  logic [1:0]  lane_sel;
  logic [1:0]  arith_mode;
  logic [63:0] opa;
  logic [63:0] opb;
  logic        out_valid;
  logic [63:0] result;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [63:0] exp_res;

  psimd_addsub dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .lane_sel(lane_sel), .arith_mode(arith_mode), .opa(opa), .opb(opb),
    .out_valid(out_valid), .result(result), .illegal_op(illegal_op)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit is_bad(input logic [1:0] ls, input logic [1:0] md);
    return (ls == 2'd3) || (md == 2'd3) || (ls == 2'd2 && md != 2'd0);
  endfunction

  // Lane model: wrap, signed clamp or unsigned clamp per lane
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic sub, input logic [1:0] ls,
                                        input logic [1:0] md);
    int n = 8 << ls;
    logic [63:0] m = (64'd1 << n) - 64'd1;
    logic [63:0] res = '0;
    longint x, y, r, lo, hi;
    for (int i = 0; i < 64 / n; i++) begin
      x = longint'((a >> (i * n)) & m);
      y = longint'((b >> (i * n)) & m);
      if (md == 2'd1) begin
        if (x >= (longint'(1) << (n - 1))) x = x - (longint'(1) << n);
        if (y >= (longint'(1) << (n - 1))) y = y - (longint'(1) << n);
      end
      r = sub ? x - y : x + y;
      if (md == 2'd1) begin
        lo = -(longint'(1) << (n - 1));
        hi = (longint'(1) << (n - 1)) - 1;
        if (r > hi) r = hi;
        if (r < lo) r = lo;
      end else if (md == 2'd2) begin
        hi = (longint'(1) << n) - 1;
        if (r > hi) r = hi;
        if (r < 0) r = 0;
      end
      res = res | ((64'(r) & m) << (i * n));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input logic sub,
                       input logic [1:0] ls, input logic [1:0] md, input string tag);
    bit bad = is_bad(ls, md);
    @(negedge clk);
    opa = a; opb = b; op_sub = sub; lane_sel = ls; arith_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (!bad) exp_res = model(a, b, sub, ls, md);
    check(tag, result, exp_res);
    check(bad ? "R6 valid" : "R7 valid", 64'(out_valid), bad ? 64'd0 : 64'd1);
    check("R6 illegal", 64'(illegal_op), bad ? 64'd1 : 64'd0);
  endtask

  function automatic logic [7:0] pick_byte(input int unsigned sel);
    case (sel % 6)
      0: return 8'h00;
      1: return 8'h7F;
      2: return 8'h80;
      3: return 8'hFF;
      4: return 8'h01;
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [63:0] rnd_word();
    logic [63:0] w;
    if ($urandom % 4 == 0) return {$urandom, $urandom};
    for (int i = 0; i < 8; i++) w[i*8 +: 8] = pick_byte($urandom);
    return w;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0;
    lane_sel = 2'd0; arith_mode = 2'd0; opa = '0; opb = '0;
    exp_res = '0;
    repeat (3) @(negedge clk);
    check("R9 result", result, 64'd0);
    check("R9 valid", 64'(out_valid), 64'd0);
    check("R9 illegal", 64'(illegal_op), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: carry dropped, no spill into neighbour lane
    do_op(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 1'b0, 2'd0, 2'd0, "R2 wrap byte");
    check("R2 byte0", result, 64'd0);
    // R1: 16-bit and 32-bit lane isolation
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b0, 2'd1, 2'd0, "R1 wrap half");
    do_op(64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0, 2'd2, 2'd0, "R1 wrap word");
    // R3: signed clamps
    do_op(64'h7F7F_8080_7F7F_8080, 64'h0101_FFFF_7F7F_8080, 1'b0, 2'd0, 2'd1, "R3 ssat byte");
    check("R3 byte values", result, 64'h7F7F_8080_7F7F_8080);
    do_op(64'h7FFF_8000_0005_FFFB, 64'h0001_0001_0003_0005, 1'b1, 2'd1, 2'd1, "R3 ssat half sub");
    // R4: unsigned clamps
    do_op(64'hFFFF_0001_F0F0_0A0A, 64'h0001_0002_2020_0101, 1'b0, 2'd0, 2'd2, "R4 usat byte");
    do_op(64'h0000_0005_1234_FFFF, 64'h0001_0006_0034_0001, 1'b1, 2'd1, 2'd2, "R4 usat half sub");
    check("R4 half values", result, 64'h0000_0000_1200_FFFE);
    // R5: wrap subtraction
    do_op(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1'b1, 2'd2, 2'd0, "R5 wrap sub");
    // R6: refused requests keep result
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 2'd2, 2'd1, "R6 sat32 signed");
    do_op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 2'd2, 2'd2, "R6 sat32 unsigned");
    do_op(64'h1234, 64'h1, 1'b0, 2'd3, 2'd0, "R6 lane rsv");
    do_op(64'h1234, 64'h1, 1'b0, 2'd0, 2'd3, "R6 mode rsv");
    // R8: idle cycle
    @(negedge clk);
    opa = '1; opb = '1;
    @(negedge clk);
    check("R8 idle valid", 64'(out_valid), 64'd0);
    check("R8 idle illegal", 64'(illegal_op), 64'd0);
    check("R8 idle result", result, exp_res);

    // Random mix
    for (int t = 0; t < 600; t++) begin
      logic [1:0] ls = 2'($urandom % 4);
      logic [1:0] md = 2'($urandom % 4);
      logic sb = 1'($urandom);
      string tg;
      if ($urandom % 8 != 0) begin
        if (ls == 2'd3) ls = 2'($urandom % 3);
        if (md == 2'd3) md = 2'($urandom % 3);
      end
      if (is_bad(ls, md))   tg = "R6 rand";
      else if (md == 2'd1)  tg = "R3 rand";
      else if (md == 2'd2)  tg = "R4 rand";
      else if (sb)          tg = "R5 rand";
      else                  tg = "R1 rand";
      do_op(rnd_word(), rnd_word(), sb, ls, md, tg);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule